// File: doc/BRIEF.md
# Endian-Selectable Byte-Addressed Data Memory

A synchronous data memory in which every 8-bit byte has its own address and the data path is one 32-bit word. A single request channel carries the address, a write flag, an access size (one byte or a full word), the write data and a per-request flag that picks big-endian or little-endian byte-lane order. Each accepted request produces exactly one response, a read value and an error flag. Internally the storage is four byte-wide banks. Bank `b` holds every byte whose address has low bits equal to `b`.

A full-word access whose address is not a multiple of four is misaligned. A build-time parameter picks what happens to such accesses. In reject mode the memory answers with an error and leaves storage untouched. In split mode it performs two back-to-back aligned accesses and stitches the bytes together. While the second half is issued, `req_ready` is low. The response channel has no back-pressure: a response is presented for exactly one cycle and must be taken then. A request is accepted only on a rising clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is low, the requester must hold its request, and nothing it presents has any effect.

Top module: `endian_byte_mem`

## Requirements
- R1: A byte write (`req_size`=0) changes only the byte at `req_addr`, using `req_wdata[7:0]`. A byte read returns that byte in `rsp_rdata[7:0]`, with bits 31..8 zero.
- R2: A little-endian word access (`req_big_endian`=0) maps the byte at address a+k to data bits 8k+7..8k, for k=0..3.
- R3: A big-endian word access (`req_big_endian`=1) maps the byte at address a+k to data bits 8(3-k)+7..8(3-k), for k=0..3.
- R4: Byte accesses and aligned word accesses answer with `rsp_valid` high for one cycle, exactly one cycle after acceptance. A write response carries `rsp_rdata`=0.
- R5: A word access is misaligned exactly when `req_addr[1:0]` is not 0. Byte accesses and aligned word accesses never raise `rsp_err`.
- R6: In reject mode (`SPLIT_UNALIGNED`=0), a misaligned word access answers one cycle after acceptance with `rsp_err`=1 for one cycle and `rsp_rdata`=0. It writes nothing.
- R7: In split mode (`SPLIT_UNALIGNED`=1), a misaligned word access covers bytes a..a+3, wrapping modulo the memory size, with the lane order of R2 or R3. `req_ready` is low in the cycle after acceptance. The response comes two cycles after acceptance, with `rsp_err`=0.
- R8: A request presented while `req_ready` is low is not accepted and changes no stored byte.
- R9: While reset is held, and after it, `rsp_valid` and `rsp_err` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Memory can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte, 1 = 32-bit word |
| req_big_endian | input | 1 | 1 = big-endian lane order, 0 = little-endian |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present for this cycle |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Misaligned access rejected |

## Verification
A wrong bank-enable or row selection shows up as a wrong byte at a different address. It is only seen when that address is read back, so every sweep ends in a full byte read-back of the memory. A wrong lane mapping or a stale hold register corrupts the response of the very access that caused it, one or two cycles after acceptance. A stuck split state shows at once as `req_ready` staying low or a missing response. Running the same sweeps against a split-mode and a reject-mode instance separates the error path from the stitching path.

// File: rtl/emem_pkg.sv
package emem_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } size_e;

  // data lane holding the k-th byte of a word access; its own inverse
  function automatic logic [1:0] lane_of(input logic [1:0] k, input logic big);
    return big ? (2'd3 - k) : k;
  endfunction
endpackage

// File: rtl/emem_align_chk.sv
module emem_align_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              size_word,
  input  logic [ADDR_W-1:0] addr,
  output logic              misaligned,
  output logic [1:0]        offset,
  output logic [ADDR_W-3:0] row
);
  assign offset     = addr[1:0];
  assign row        = addr[ADDR_W-1:2];
  assign misaligned = size_word && (addr[1:0] != 2'd0);
endmodule

// File: rtl/emem_byte_bank.sv
module emem_byte_bank #(
  parameter int unsigned ROW_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wbyte,
  output logic [7:0]       q
);
  localparam int unsigned DEPTH = 2 ** ROW_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[row] <= wbyte;
    q <= cells[row];
  end
endmodule

// File: rtl/emem_wr_steer.sv
module emem_wr_steer
  import emem_pkg::*;
(
  input  logic                          we,
  input  logic                          size_word,
  input  logic                          big,
  input  logic                          phase_b,
  input  logic [1:0]                    off,
  input  logic [WORD_W-1:0]             wdata,
  output logic [LANES-1:0]              bank_we,
  output logic [LANES-1:0][LANE_W-1:0]  bank_wbyte
);
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    localparam logic [1:0] BI = 2'(b);
    logic [1:0] k;
    logic [1:0] lane;
    logic       active;

    always_comb begin
      k    = BI - off;
      lane = size_word ? lane_of(k, big) : 2'd0;
      if (size_word) active = phase_b ? (BI < off) : (BI >= off);
      else           active = (BI == off);
      bank_we[b]    = we && active;
      bank_wbyte[b] = wdata[{lane, 3'b000} +: LANE_W];
    end
  end
endmodule

// File: rtl/emem_rd_gather.sv
module emem_rd_gather
  import emem_pkg::*;
(
  input  logic                          rd_en,
  input  logic                          size_word,
  input  logic                          big,
  input  logic                          split,
  input  logic [1:0]                    off,
  input  logic [LANES-1:0][LANE_W-1:0]  live,
  input  logic [LANES-1:0][LANE_W-1:0]  hold,
  output logic [WORD_W-1:0]             rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [1:0] LI = 2'(l);
    logic [1:0]        k;
    logic [1:0]        bsel;
    logic [LANE_W-1:0] pick;

    always_comb begin
      k    = lane_of(LI, big);
      bsel = off + k;
      if (size_word) begin
        pick = (split && (bsel >= off)) ? hold[bsel] : live[bsel];
      end else begin
        pick = (LI == 2'd0) ? live[off] : '0;
      end
      rdata[l*LANE_W +: LANE_W] = rd_en ? pick : '0;
    end
  end
endmodule

// File: rtl/endian_byte_mem.sv
module endian_byte_mem
  import emem_pkg::*;
#(
  parameter int unsigned ADDR_W          = 6,
  parameter bit          SPLIT_UNALIGNED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic              req_size,
  input  logic              req_big_endian,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);
  localparam int unsigned    ROW_W   = ADDR_W - 2;
  localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);

  logic             req_mis;
  logic [1:0]       req_off;
  logic [ROW_W-1:0] req_row;

  emem_align_chk #(.ADDR_W(ADDR_W)) u_align (
    .size_word (req_size),
    .addr      (req_addr),
    .misaligned(req_mis),
    .offset    (req_off),
    .row       (req_row)
  );

  // second-half state for a split access
  logic             busy;
  logic             st_we;
  logic             st_big;
  logic [1:0]       st_off;
  logic [ROW_W-1:0] st_row;
  logic [31:0]      st_wdata;

  logic accept;
  logic reject;
  logic start_split;

  assign req_ready   = !busy;
  assign accept      = req_valid && req_ready;
  assign reject      = accept && req_mis && !SPLIT_UNALIGNED;
  assign start_split = accept && req_mis && SPLIT_UNALIGNED;

  // issue side of the banks
  logic             iss_we;
  logic             iss_size;
  logic             iss_big;
  logic [1:0]       iss_off;
  logic [ROW_W-1:0] iss_row;
  logic [31:0]      iss_wdata;

  always_comb begin
    if (busy) begin
      iss_we    = st_we;
      iss_size  = SZ_WORD;
      iss_big   = st_big;
      iss_off   = st_off;
      iss_row   = st_row + ROW_ONE;
      iss_wdata = st_wdata;
    end else begin
      iss_we    = accept && req_we && !reject;
      iss_size  = req_size;
      iss_big   = req_big_endian;
      iss_off   = req_off;
      iss_row   = req_row;
      iss_wdata = req_wdata;
    end
  end

  logic [LANES-1:0]             bank_we;
  logic [LANES-1:0][LANE_W-1:0] bank_wbyte;
  logic [LANES-1:0][LANE_W-1:0] bank_q;
  logic [LANES-1:0][LANE_W-1:0] hold_q;

  emem_wr_steer u_steer (
    .we        (iss_we),
    .size_word (iss_size),
    .big       (iss_big),
    .phase_b   (busy),
    .off       (iss_off),
    .wdata     (iss_wdata),
    .bank_we   (bank_we),
    .bank_wbyte(bank_wbyte)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    emem_byte_bank #(.ROW_W(ROW_W)) u_bank (
      .clk  (clk),
      .we   (bank_we[b]),
      .row  (iss_row),
      .wbyte(bank_wbyte[b]),
      .q    (bank_q[b])
    );
  end

  // first-half read bytes are held while the second half is read
  always_ff @(posedge clk) begin
    if (busy) hold_q <= bank_q;
  end

  logic       rsp_valid_q;
  logic       rsp_err_q;
  logic       rsp_rd_q;
  logic       rsp_split_q;
  logic       rsp_size_q;
  logic       rsp_big_q;
  logic [1:0] rsp_off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      st_we       <= 1'b0;
      st_big      <= 1'b0;
      st_off      <= '0;
      st_row      <= '0;
      st_wdata    <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rd_q    <= 1'b0;
      rsp_split_q <= 1'b0;
      rsp_size_q  <= 1'b0;
      rsp_big_q   <= 1'b0;
      rsp_off_q   <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      if (busy) begin
        busy        <= 1'b0;
        rsp_valid_q <= 1'b1;
        rsp_rd_q    <= !st_we;
        rsp_split_q <= 1'b1;
        rsp_size_q  <= SZ_WORD;
        rsp_big_q   <= st_big;
        rsp_off_q   <= st_off;
      end else if (accept) begin
        if (start_split) begin
          busy     <= 1'b1;
          st_we    <= req_we;
          st_big   <= req_big_endian;
          st_off   <= req_off;
          st_row   <= req_row;
          st_wdata <= req_wdata;
        end else begin
          rsp_valid_q <= 1'b1;
          rsp_err_q   <= req_mis;
          rsp_rd_q    <= !req_we;
          rsp_split_q <= 1'b0;
          rsp_size_q  <= req_size;
          rsp_big_q   <= req_big_endian;
          rsp_off_q   <= req_off;
        end
      end
    end
  end

  emem_rd_gather u_gather (
    .rd_en    (rsp_valid_q && rsp_rd_q && !rsp_err_q),
    .size_word(rsp_size_q),
    .big      (rsp_big_q),
    .split    (rsp_split_q),
    .off      (rsp_off_q),
    .live     (bank_q),
    .hold     (hold_q),
    .rdata    (rsp_rdata)
  );

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
endmodule

// File: rtl/emem_checker.sv
module emem_checker #(
  parameter bit SPLIT_UNALIGNED = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_we,
  input logic        req_size,
  input logic [1:0]  addr_lo,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        rsp_err
);
  logic acc;
  logic mis;
  assign acc = req_valid && req_ready;
  assign mis = req_size && (addr_lo != 2'd0);

  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid); // R6
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 32'd0)); // R6
  AST_ONE_CYCLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !mis) |=> rsp_valid); // R4
  AST_WRITE_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !mis && req_we) |=> (rsp_rdata == 32'd0)); // R4
  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_size && !req_we) |=> (rsp_rdata[31:8] == 24'd0)); // R1
  AST_NO_ERR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !mis) |=> !rsp_err); // R5
  AST_READY_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready); // R8

  if (SPLIT_UNALIGNED) begin : g_split
    AST_SPLIT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && mis) |=> (!req_ready && !rsp_valid)); // R7
    AST_SPLIT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && mis) |=> ##1 (rsp_valid && !rsp_err)); // R7
  end else begin : g_reject
    AST_REJECT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && mis) |=> rsp_err); // R6
  end
endmodule

bind endian_byte_mem emem_checker #(.SPLIT_UNALIGNED(SPLIT_UNALIGNED)) u_emem_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_we   (req_we),
  .req_size (req_size),
  .addr_lo  (req_addr[1:0]),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata),
  .rsp_err  (rsp_err)
);

// File: tb/test_endian_byte_mem.sv
module test_endian_byte_mem;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NB = 2 ** AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vs = 1'b0, vr = 1'b0;
  logic we = 1'b0, sz = 1'b0, big = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wd = '0;
  logic rdy_s, rv_s, er_s, rdy_r, rv_r, er_r;
  logic [31:0] rd_s, rd_r;

  logic [7:0] ms [NB];
  logic [7:0] mr [NB];
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  endian_byte_mem #(.ADDR_W(AW), .SPLIT_UNALIGNED(1'b1)) i_endian_byte_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(vs), .req_ready(rdy_s), .req_we(we),
    .req_size(sz), .req_big_endian(big), .req_addr(addr), .req_wdata(wd),
    .rsp_valid(rv_s), .rsp_rdata(rd_s), .rsp_err(er_s));

  endian_byte_mem #(.ADDR_W(AW), .SPLIT_UNALIGNED(1'b0)) i_endian_byte_mem_rej (
    .clk(clk), .rst_n(rst_n), .req_valid(vr), .req_ready(rdy_r), .req_we(we),
    .req_size(sz), .req_big_endian(big), .req_addr(addr), .req_wdata(wd),
    .rsp_valid(rv_r), .rsp_rdata(rd_r), .rsp_err(er_r));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [31:0] exp_rd(input bit on_s, input logic [AW-1:0] a,
                                         input logic s, input logic b);
    logic [31:0] r;
    logic [7:0]  v;
    r = '0;
    if (!s) begin
      r[7:0] = on_s ? ms[a] : mr[a];
    end else begin
      for (int k = 0; k < 4; k++) begin
        int ln;
        logic [AW-1:0] ad;
        ad = a + AW'(k);
        v  = on_s ? ms[ad] : mr[ad];
        ln = b ? 3 - k : k;
        r[ln*8 +: 8] = v;
      end
    end
    return r;
  endfunction

  task automatic model_wr(input bit on_s, input logic [AW-1:0] a, input logic s,
                          input logic b, input logic [31:0] d);
    if (!s) begin
      if (on_s) ms[a] = d[7:0]; else mr[a] = d[7:0];
    end else begin
      for (int k = 0; k < 4; k++) begin
        int ln;
        logic [AW-1:0] ad;
        ad = a + AW'(k);
        ln = b ? 3 - k : k;
        if (on_s) ms[ad] = d[ln*8 +: 8]; else mr[ad] = d[ln*8 +: 8];
      end
    end
  endtask

  task automatic access(input logic w, input logic s, input logic b,
                        input logic [AW-1:0] a, input logic [31:0] d, input string rq);
    logic mis;
    logic [31:0] es, er;
    mis = s && (a[1:0] != 2'd0);
    es  = w ? 32'd0 : exp_rd(1'b1, a, s, b);
    er  = (w || mis) ? 32'd0 : exp_rd(1'b0, a, s, b);
    if (w) model_wr(1'b1, a, s, b, d);
    if (w && !mis) model_wr(1'b0, a, s, b, d);
    @(negedge clk);
    we = w; sz = s; big = b; addr = a; wd = d; vs = 1'b1; vr = 1'b1;
    @(negedge clk);
    vs = 1'b0; vr = 1'b0;
    // reject instance: answer one cycle after acceptance
    chk(rv_r === 1'b1, {rq, " R4 rej rsp_valid"}, 32'(rv_r), 32'd1);
    chk(er_r === mis, mis ? {rq, " R6 err"} : {rq, " R5 err"}, 32'(er_r), 32'(mis));
    chk(rd_r === er, {rq, " rej data"}, rd_r, er);
    if (mis) begin
      chk(rdy_s === 1'b0 && rv_s === 1'b0, {rq, " R7 stall"}, {30'd0, rdy_s, rv_s}, 32'd0);
      @(negedge clk);
      chk(rv_r === 1'b0 && er_r === 1'b0, {rq, " R6 one-cycle err"}, {30'd0, rv_r, er_r}, 32'd0);
    end
    chk(rv_s === 1'b1 && er_s === 1'b0, {rq, " split rsp"}, {30'd0, rv_s, er_s}, 32'd2);
    chk(rd_s === es, {rq, " split data"}, rd_s, es);
  endtask

  task automatic read_back(input string rq);
    for (int a = 0; a < NB; a++) access(1'b0, 1'b0, 1'b0, AW'(a), 32'd0, rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdy_s === 1'b1 && rv_s === 1'b0 && er_s === 1'b0, "R9 reset split", {29'd0, rdy_s, rv_s, er_s}, 32'd4);
    chk(rdy_r === 1'b1 && rv_r === 1'b0 && er_r === 1'b0, "R9 reset rej", {29'd0, rdy_r, rv_r, er_r}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_s === 1'b1 && rv_s === 1'b0, "R9 after reset", {30'd0, rdy_s, rv_s}, 32'd2);

    // R1: byte fill with junk in upper lanes, then byte read-back
    for (int a = 0; a < NB; a++)
      access(1'b1, 1'b0, 1'b0, AW'(a), {8'hA5, 8'h5A, 8'hC3, 8'((a * 37 + 11) & 8'hFF)}, "R1 fill");
    read_back("R1 readback");

    // R2 / R3: aligned word reads in both orders
    for (int w = 0; w < NB / 4; w++) begin
      access(1'b0, 1'b1, 1'b0, AW'(w * 4), 32'd0, "R2 word read");
      access(1'b0, 1'b1, 1'b1, AW'(w * 4), 32'd0, "R3 word read");
    end

    // R2 / R3: aligned word writes, checked bytewise
    for (int w = 0; w < NB / 4; w++)
      access(1'b1, 1'b1, w[0], AW'(w * 4), 32'h1234_5678 ^ (32'(w) * 32'h0101_0101),
             w[0] ? "R3 word write" : "R2 word write");
    read_back("R2 R3 readback");

    // R5 R6 R7: misaligned reads in both orders
    for (int a = 0; a < NB; a++) begin
      if (a % 4 != 0) begin
        access(1'b0, 1'b1, 1'b0, AW'(a), 32'd0, "R7 mis read le");
        access(1'b0, 1'b1, 1'b1, AW'(a), 32'd0, "R7 mis read be");
      end
    end

    // R6 R7: misaligned writes; reject side must stay untouched
    for (int a = 0; a < NB; a++) begin
      if (a % 4 != 0)
        access(1'b1, 1'b1, a[2], AW'(a), {8'(a), 8'(~a), 8'(a + 3), 8'(a ^ 8'h5C)}, "R7 mis write");
    end
    read_back("R6 R7 readback");

    // R8: a request presented during the split stall is ignored
    begin
      logic [31:0] e9;
      e9 = exp_rd(1'b1, AW'(9), 1'b1, 1'b0);
      @(negedge clk);
      we = 1'b0; sz = 1'b1; big = 1'b0; addr = AW'(9); vs = 1'b1;
      @(negedge clk);
      chk(rdy_s === 1'b0, "R8 ready low", 32'(rdy_s), 32'd0);
      we = 1'b1; sz = 1'b0; addr = AW'(20); wd = 32'h0000_003C;
      @(negedge clk);
      vs = 1'b0; we = 1'b0;
      chk(rv_s === 1'b1 && rd_s === e9, "R7 R8 split read", rd_s, e9);
      access(1'b0, 1'b0, 1'b0, AW'(20), 32'd0, "R8 ignored write");
    end

    summary();
    $finish;
  end
endmodule